// File: doc/BRIEF.md
# Protection-Aware Memory Checksum Unit

This block forms a 16-bit checksum over a program memory image that arrives one word per beat. A run opens with a start pulse, which clears the running sum. Each valid beat adds one word. The beat that carries the last flag closes the stream. On the next cycle the unit adds the configuration term and raises done. The result then stays on the output until the next start.

When the protect flag is set, each incoming word is first rewritten the way a read-protected part presents it on readout. The eight-bit XNOR of its upper and lower bytes is placed in both byte lanes. The configuration word is always added in its raw form, ANDed with a caller-supplied mask. A legacy enable also adds a fixed constant, for older parts whose checksums carry that extra term.

Walking the address space and reading the memory belong to the caller. The stream therefore defines the range that is summed.

Top module: `prot_cksum_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `checksum` is 0x0000 and `done` is 0.
- R2: A `start` pulse clears the sum to 0x0000 and drops `done` on the next edge, in any state, including in the middle of a run.
- R3: With `protect` low, every accepted beat adds `in_word` to the sum, modulo 2^16.
- R4: With `protect` high, every accepted beat adds {x, x}, where x = ~(in_word[15:8] ^ in_word[7:0]).
- R5: The edge after the one that accepts the beat with `in_last` high adds (`cfg_word` & `cfg_mask`) to the sum and raises `done` at the same time. The configuration word is never scrambled.
- R6: When `legacy_en` is high on that folding cycle, the constant 0xFFA0 is also added.
- R7: During a run, a cycle with `in_valid` low leaves the sum unchanged, so gaps between beats have no effect.
- R8: Beats offered before the first `start`, or after `done`, are ignored: `checksum` and `done` hold.
- R9: Once `done` is high, it stays high and `checksum` stays constant until the next `start`.
- R10: When `start` and `in_valid` are high in the same cycle, the word is dropped and the new run begins from 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears the sum and opens a run |
| in_valid | input | 1 | `in_word` carries a word this cycle |
| in_last | input | 1 | Marks the final word of the image |
| in_word | input | 16 | Program memory word |
| protect | input | 1 | Apply the protected-readout scramble to words |
| cfg_word | input | 16 | Configuration word, held until `done` |
| cfg_mask | input | 16 | Mask applied to the configuration word |
| legacy_en | input | 1 | Add the legacy constant 0xFFA0 when folding |
| checksum | output | 16 | Running sum, final once `done` is high |
| done | output | 1 | Checksum complete |

## Verification
A fault in the scramble path or in the accumulator shows up only in the final value. Every image therefore compares `checksum` on the first cycle that `done` is high.

A sequencer stuck in the wrong phase shows up sooner. Within one cycle it either shifts when `done` rises, or lets an ignored beat disturb a held result.

The single-word sweeps cover every high-byte value in both modes. Any wrong bit in the XNOR lane therefore appears in the first image that exercises it.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned HALF_W = WORD_W / 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FOLD = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic clr;
        logic add_word;
        logic add_cfg;
    } acc_ctl_t;

    function automatic word_t cfg_term(input word_t cfg, input word_t mask,
                                       input logic legacy, input word_t lconst);
        return (cfg & mask) + (legacy ? lconst : '0);
    endfunction

endpackage

// File: rtl/cks_word_xform.sv
module cks_word_xform
    import cksum_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] word_i,
    input  logic         protect_i,
    output logic [W-1:0] word_o
);
    localparam int unsigned H = W / 2;

    logic [H-1:0] folded;

    for (genvar b = 0; b < H; b++) begin : g_lane
        assign folded[b] = ~(word_i[b+H] ^ word_i[b]);
    end

    assign word_o = protect_i ? {folded, folded} : word_i;
endmodule

// File: rtl/cks_sequencer.sv
module cks_sequencer
    import cksum_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     valid_i,
    input  logic     last_i,
    output acc_ctl_t ctl_o,
    output phase_e   phase_o,
    output logic     done_o
);
    phase_e phase_q, phase_d;

    always_comb begin
        phase_d        = phase_q;
        ctl_o          = '0;
        if (start_i) begin
            ctl_o.clr = 1'b1;
            phase_d   = PH_RUN;
        end else begin
            unique case (phase_q)
                PH_RUN: begin
                    if (valid_i) begin
                        ctl_o.add_word = 1'b1;
                        if (last_i) phase_d = PH_FOLD;
                    end
                end
                PH_FOLD: begin
                    ctl_o.add_cfg = 1'b1;
                    phase_d       = PH_DONE;
                end
                default: phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase_o = phase_q;
    assign done_o  = (phase_q == PH_DONE);
endmodule

// File: rtl/cks_accum.sv
module cks_accum
    import cksum_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_ctl_t     ctl_i,
    input  logic [W-1:0] word_i,
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] sum_q;
    logic [W-1:0] operand;

    always_comb begin
        operand = '0;
        if (ctl_i.add_word) operand = word_i;
        if (ctl_i.add_cfg)  operand = cfg_i;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clr)                   sum_q <= '0;
        else if (ctl_i.add_word || ctl_i.add_cfg) sum_q <= sum_q + operand;
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/prot_cksum_unit.sv
module prot_cksum_unit
    import cksum_pkg::*;
#(
    parameter logic [15:0] LEGACY_CONST = 16'hFFA0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        in_valid,
    input  logic        in_last,
    input  logic [15:0] in_word,
    input  logic        protect,
    input  logic [15:0] cfg_word,
    input  logic [15:0] cfg_mask,
    input  logic        legacy_en,
    output logic [15:0] checksum,
    output logic        done
);
    acc_ctl_t ctl;
    phase_e   phase;
    word_t    xf_word;
    word_t    cfg_add;

    cks_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .valid_i (in_valid),
        .last_i  (in_last),
        .ctl_o   (ctl),
        .phase_o (phase),
        .done_o  (done)
    );

    cks_word_xform #(.W(WORD_W)) u_xf (
        .word_i    (in_word),
        .protect_i (protect),
        .word_o    (xf_word)
    );

    assign cfg_add = cfg_term(cfg_word, cfg_mask, legacy_en, LEGACY_CONST);

    cks_accum #(.W(WORD_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .word_i (xf_word),
        .cfg_i  (cfg_add),
        .sum_o  (checksum)
    );
endmodule

// File: rtl/prot_cksum_unit_chk.sv
module prot_cksum_unit_chk
    import cksum_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        in_valid,
    input logic [15:0] checksum,
    input logic        done,
    input phase_e      phase
);
    logic seen_clk;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        seen_clk && $past(rst) |-> (checksum == 16'h0000) && !done);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (checksum == 16'h0000) && !done);

    assert_gap_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN) && !in_valid && !start |=> $stable(checksum));

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(checksum));

    assert_idle_ignores_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) && !start |=> $stable(checksum) && !done);

    assert_fold_then_done_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FOLD) && !start |=> done);
endmodule

bind prot_cksum_unit prot_cksum_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .checksum (checksum),
    .done     (done),
    .phase    (phase)
);

// File: tb/prot_cksum_unit_tb.sv
module prot_cksum_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
    logic [15:0] in_word = '0, cfg_word = '0, cfg_mask = '0;
    logic        protect = 1'b0, legacy_en = 1'b0;
    logic [15:0] checksum;
    logic        done;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    logic [15:0] img[];

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_cksum_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_last(in_last), .in_word(in_word), .protect(protect),
        .cfg_word(cfg_word), .cfg_mask(cfg_mask), .legacy_en(legacy_en),
        .checksum(checksum), .done(done)
    );

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected under %0d", cyc, WATCHDOG);
            report();
        end
    end

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_word(logic [15:0] w, logic p);
        logic [7:0] x;
        x = 8'hFF ^ ((w >> 8) ^ (w & 16'h00FF));
        return p ? (16'(x) * 16'h0101) : w;
    endfunction

    function automatic logic [15:0] ref_sum(logic p, logic [15:0] c, logic [15:0] m, logic l);
        logic [15:0] s = 0;
        foreach (img[i]) s = s + ref_word(img[i], p);
        s = s + (c & m);
        if (l) s = s + 16'hFFA0;
        return s;
    endfunction

    // Streams img with optional one-cycle gaps; returns after done should be up.
    task automatic run(string req, logic p, logic [15:0] c, logic [15:0] m,
                       logic l, bit gaps);
        protect = p; cfg_word = c; cfg_mask = m; legacy_en = l;
        start = 1; @(negedge clk); start = 0;
        foreach (img[i]) begin
            if (gaps) begin in_valid = 0; in_word = 16'hDEAD; @(negedge clk); end
            in_valid = 1; in_word = img[i]; in_last = (i == img.size() - 1);
            @(negedge clk);
        end
        in_valid = 0; in_last = 0;
        n_cmp++;
        if (done !== 1'b0) begin n_bad++; $display("FAIL R5: done early actual %b expected 0", done); end
        @(negedge clk);
        check(req, {done, checksum}, {1'b1, ref_sum(p, c, m, l)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {done, checksum}, 17'h0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", {done, checksum}, 17'h0);

        // R8: beats before any start are ignored
        in_valid = 1; in_word = 16'h4321; in_last = 1;
        repeat (3) @(negedge clk);
        in_valid = 0; in_last = 0;
        check("R8 pre-start", {done, checksum}, 17'h0);

        // Blank 2K image, unprotected, mask 0x015F: expect 0xF95F (R3, R5)
        img = new[2048];
        foreach (img[i]) img[i] = 16'hFFFF;
        run("R3 blank", 0, 16'hFFFF, 16'h015F, 0, 0);
        check("R3 blank literal", {1'b0, checksum}, 17'h0F95F);
        // Legacy term: mask 0x005F plus 0xFFA0 (R6)
        run("R6 legacy blank", 0, 16'hFFFF, 16'h005F, 1, 0);
        check("R6 literal", {1'b0, checksum}, 17'h0F7FF);
        // Marker 0xC0DE at first and last word (R3, R4)
        img[0] = 16'hC0DE; img[2047] = 16'hC0DE;
        run("R3 marker", 0, 16'hFFFF, 16'h015F, 0, 0);
        check("R3 marker literal", {1'b0, checksum}, 17'h07B1D);
        run("R4 marker protected", 1, 16'h000F, 16'h015F, 0, 0);
        check("R4 marker literal", {1'b0, checksum}, 17'h0BBD3);

        // R9 / R8: beats after done are ignored, result holds
        in_valid = 1; in_word = 16'h1111; in_last = 1;
        repeat (4) @(negedge clk);
        in_valid = 0; in_last = 0;
        check("R9 hold after done", {done, checksum}, {1'b1, 16'hBBD3});

        // R7: gaps between beats
        img = new[5];
        foreach (img[i]) img[i] = 16'h1234 * 16'(i + 3);
        run("R7 gaps", 0, 16'hA5A5, 16'hFFFF, 0, 1);
        run("R7 gaps protected", 1, 16'h5A5A, 16'h00F0, 1, 1);

        // R10: start with valid in same cycle drops the word
        img = new[2]; img[0] = 16'h0100; img[1] = 16'h0002;
        protect = 0; cfg_word = 0; cfg_mask = 0; legacy_en = 0;
        start = 1; in_valid = 1; in_word = 16'h7777; @(negedge clk);
        start = 0; in_valid = 1; in_word = img[0]; @(negedge clk);
        in_word = img[1]; in_last = 1; @(negedge clk);
        in_valid = 0; in_last = 0; @(negedge clk);
        check("R10 start drops word", {done, checksum}, {1'b1, 16'h0102});

        // R2: restart in the middle of a run
        start = 1; @(negedge clk); start = 0;
        check("R2 cleared", {done, checksum}, 17'h0);
        in_valid = 1; in_word = 16'h0F0F; @(negedge clk); @(negedge clk);
        in_valid = 0;
        img = new[1]; img[0] = 16'h0042;
        run("R2 restart", 0, 16'h0001, 16'h0001, 0, 0);

        // Near-exhaustive single-word sweep over high byte, both modes (R3, R4)
        for (int h = 0; h < 256; h++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] lo;
                lo = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'(h * 7);
                img[0] = {8'(h), lo};
                run("R3 sweep", 0, 16'(h * 131), 16'h015F, k[0], 0);
                run("R4 sweep", 1, 16'(h * 257), 16'h015F, k[1], 0);
            end
        end

        finished = 1;
        report();
    end
endmodule